// File: doc/BRIEF.md
# Hierarchical Status Register Tree

This block keeps a three-tier set of latched status registers for a multi-channel instrument. Each group in the tree has a live condition view, an event register that latches rising condition edges, and an enable register that chooses which latched events reach the group's summary. Every channel has its own 16-bit group. A channel's summary becomes one condition bit of an instrument-level group. The summary of the instrument group becomes condition bit 13 of the top-level group. The top-level summary is the output that the status byte logic consumes.

Software reaches the tree through a single read port and a single enable-write port. Both select a group and a register kind. Reading an event register returns its value and clears it at the end of that cycle. A clear-status strobe empties every event and enable register. `rst_n` is the power-up reset and clears all state. `dev_rst` is the device reset: it clears the enable registers and leaves the latched events in place.

Top module: `stat_tree`

## Requirements
- R1: A read with kind 0 (condition) returns the selected group's live condition ANDed with that group's bit mask, in the same cycle. It never clears or changes any event bit.
- R2: A 0-to-1 change of a masked condition bit sets the matching event bit at the next clock edge. The bit then stays set when the condition falls, until it is cleared by R3 or R4.
- R3: A read with kind 1 (event) returns the group's event register and clears it at the clock edge that ends the read cycle. A condition rise that lands on that same edge is latched, not lost.
- R4: While `clr_stat` is high at an edge, every event register and every enable register is cleared. A condition rise on that edge is still latched.
- R5: While `dev_rst` is high at an edge, every enable register is cleared and every event register keeps its value.
- R6: `wr_en` writes `wr_data` ANDed with the group mask into the selected enable register, so writing zero clears it. A read with kind 2 returns the enable register. `summary_out` is high exactly when the top-level event and enable registers share a set bit.
- R7: Group masks: the channel mask is 0x0713 (bits 0, 1, 4, 8, 9, 10), the top-level mask is 0x3838 (bits 3, 4, 5, 11, 12, 13), and the instrument mask holds bits 1 to NUM_CH. Bit 13 of `top_cond` is ignored, because the tree drives that position. Masked-out positions always read as zero.
- R8: Channel c's summary is instrument condition bit c+1. The instrument summary is top-level condition bit 13. With all enables set, a channel event latched at edge E sets the instrument event at E+1 and the top-level bit-13 event at E+2. `summary_out` rises just after E+2.
- R9: `rd_grp`/`wr_grp` code 0 selects the top group, 1 the instrument group, and 2+c channel c. Read kind 3 returns zero. After power-up reset, all registers read zero and `summary_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset, clears all state |
| dev_rst | input | 1 | Device reset strobe, clears enable registers only |
| clr_stat | input | 1 | Clear-status strobe, clears events and enables |
| top_cond | input | 16 | Live top-level conditions (bit 13 ignored) |
| ch_cond | input | 16*NUM_CH | Live per-channel conditions, channel c in bits 16c+15..16c |
| rd_en | input | 1 | Read strobe |
| rd_grp | input | GW | Group selected for reading |
| rd_kind | input | 2 | Register kind: 0 condition, 1 event, 2 enable, 3 none |
| rd_data | output | 16 | Read data, valid in the strobe cycle |
| wr_en | input | 1 | Enable-register write strobe |
| wr_grp | input | GW | Group selected for writing |
| wr_data | input | 16 | Enable value to write |
| summary_out | output | 1 | Top-level summary toward the status byte |

## Verification
The bench builds the block with its default of six channels and 16-bit groups. At that size every bit position of every channel and of the top group can be swept one at a time. Each position is checked for its condition view, its sticky event, and its clear-on-read, against masks computed from the bit weights. The same small configuration keeps the full path short: a channel event, through the instrument group, to bit 13 and the summary output. That makes it possible to check the exact two-edge cascade latency. It also makes reachable the collisions between a read-clear and a condition rise, and the different effects of the clear-status and device-reset strobes.

// File: rtl/stat_pkg.sv
// Shared definitions for the status tree: register width, group masks and
// the register-kind encoding used on the read port.
package stat_pkg;
    localparam int          REG_W    = 16;
    localparam logic [15:0] CH_MASK  = 16'h0713;
    localparam logic [15:0] TOP_MASK = 16'h3838;
    localparam int          INST_BIT = 13;

    typedef enum logic [1:0] {
        RK_COND   = 2'd0,
        RK_EVENT  = 2'd1,
        RK_ENABLE = 2'd2,
        RK_NONE   = 2'd3
    } rd_kind_t;
endpackage

// File: rtl/stat_group.sv
// One condition/event/enable group.
// Event bits latch rising edges of the masked condition. They clear on an
// event read or on clear-status; a rise on a clearing edge is still kept.
// The enable register clears on clear-status or device reset, and those
// clears take priority over a write.
// Assumes: all strobes are single-cycle, synchronous to clk.
module stat_group #(
    parameter int          W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond,
    input  logic         ev_rd_clr,
    input  logic         stat_clr,
    input  logic         en_clr,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] cond_m,
    output logic [W-1:0] event_q,
    output logic [W-1:0] enable_q,
    output logic         summary
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;

    // Masked live condition and its rising edges.
    assign cond_m = cond & MASK;
    assign rise   = cond_m & ~prev_q;

    // Track the previous condition and latch events with clear-then-set order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            event_q <= '0;
        end else begin
            prev_q  <= cond_m;
            event_q <= ((ev_rd_clr || stat_clr) ? '0 : event_q) | rise;
        end
    end

    // Enable register: clears win over a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (stat_clr || en_clr)
            enable_q <= '0;
        else if (en_wr)
            enable_q <= en_wdata & MASK;
    end

    // Group summary: any enabled latched event.
    assign summary = |(event_q & enable_q);
endmodule

// File: rtl/stat_rd_mux.sv
// Read multiplexer over all groups of the tree.
// Picks the group by code and the register by kind; kind 3 and codes
// beyond the last group give zero.
// Assumes: group g's registers sit at bits g*W +: W of the packed inputs.
module stat_rd_mux
    import stat_pkg::*;
#(
    parameter int NG = 8,
    parameter int GW = 3,
    parameter int W  = 16
) (
    input  logic [NG*W-1:0] cond_all,
    input  logic [NG*W-1:0] ev_all,
    input  logic [NG*W-1:0] en_all,
    input  logic [GW-1:0]   rd_grp,
    input  logic [1:0]      rd_kind,
    output logic [W-1:0]    rd_data
);
    // Select the addressed group and register kind.
    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NG; g++) begin
            if (rd_grp == GW'(g)) begin
                case (rd_kind_t'(rd_kind))
                    RK_COND:   rd_data = cond_all[g*W +: W];
                    RK_EVENT:  rd_data = ev_all[g*W +: W];
                    RK_ENABLE: rd_data = en_all[g*W +: W];
                    default:   rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/stat_tree.sv
// Three-tier status tree: NUM_CH channel groups feed an instrument group,
// whose summary drives bit INST_BIT of the top-level group.
// Group code 0 is top, 1 is instrument, 2+c is channel c.
// Assumes: NUM_CH is between 1 and 14, so that instrument bits 1..NUM_CH fit
// in 16 bits.
module stat_tree
    import stat_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int NG     = NUM_CH + 2,
    parameter int GW     = $clog2(NG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dev_rst,
    input  logic                    clr_stat,
    input  logic [REG_W-1:0]        top_cond,
    input  logic [REG_W*NUM_CH-1:0] ch_cond,
    input  logic                    rd_en,
    input  logic [GW-1:0]           rd_grp,
    input  logic [1:0]              rd_kind,
    output logic [REG_W-1:0]        rd_data,
    input  logic                    wr_en,
    input  logic [GW-1:0]           wr_grp,
    input  logic [REG_W-1:0]        wr_data,
    output logic                    summary_out
);
    localparam logic [REG_W-1:0] INST_MASK =
        REG_W'(((32'd1 << (NUM_CH + 1)) - 32'd1) & 32'hFFFE);

    logic [NG-1:0]       rd_clr_hit;
    logic [NG-1:0]       wr_hit;
    logic [NG*REG_W-1:0] cond_all, ev_all, en_all;
    logic [NUM_CH-1:0]   ch_sum;
    logic [REG_W-1:0]    inst_cond;
    logic                inst_sum;
    logic [REG_W-1:0]    top_in;
    logic [REG_W-1:0]    top_ev_q, top_en_q, inst_en_q;

    // Per-group decode of event-read clears and enable writes.
    for (genvar g = 0; g < NG; g++) begin : g_dec
        assign rd_clr_hit[g] = rd_en && (rd_kind == RK_EVENT) && (rd_grp == GW'(g));
        assign wr_hit[g]     = wr_en && (wr_grp == GW'(g));
    end

    // Channel groups, one per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        stat_group #(.W(REG_W), .MASK(CH_MASK)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .cond     (ch_cond[c*REG_W +: REG_W]),
            .ev_rd_clr(rd_clr_hit[c+2]),
            .stat_clr (clr_stat),
            .en_clr   (dev_rst),
            .en_wr    (wr_hit[c+2]),
            .en_wdata (wr_data),
            .cond_m   (cond_all[(c+2)*REG_W +: REG_W]),
            .event_q  (ev_all[(c+2)*REG_W +: REG_W]),
            .enable_q (en_all[(c+2)*REG_W +: REG_W]),
            .summary  (ch_sum[c])
        );
    end

    // Channel summaries occupy instrument bits 1..NUM_CH.
    assign inst_cond = REG_W'({ch_sum, 1'b0});

    stat_group #(.W(REG_W), .MASK(INST_MASK)) u_inst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond     (inst_cond),
        .ev_rd_clr(rd_clr_hit[1]),
        .stat_clr (clr_stat),
        .en_clr   (dev_rst),
        .en_wr    (wr_hit[1]),
        .en_wdata (wr_data),
        .cond_m   (cond_all[1*REG_W +: REG_W]),
        .event_q  (ev_all[1*REG_W +: REG_W]),
        .enable_q (inst_en_q),
        .summary  (inst_sum)
    );
    assign en_all[1*REG_W +: REG_W] = inst_en_q;

    // Top-level condition: external bits with the tree summary spliced in.
    always_comb begin
        top_in           = top_cond;
        top_in[INST_BIT] = inst_sum;
    end

    stat_group #(.W(REG_W), .MASK(TOP_MASK)) u_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond     (top_in),
        .ev_rd_clr(rd_clr_hit[0]),
        .stat_clr (clr_stat),
        .en_clr   (dev_rst),
        .en_wr    (wr_hit[0]),
        .en_wdata (wr_data),
        .cond_m   (cond_all[0 +: REG_W]),
        .event_q  (top_ev_q),
        .enable_q (top_en_q),
        .summary  (summary_out)
    );
    assign ev_all[0 +: REG_W] = top_ev_q;
    assign en_all[0 +: REG_W] = top_en_q;

    stat_rd_mux #(.NG(NG), .GW(GW), .W(REG_W)) u_mux (
        .cond_all(cond_all),
        .ev_all  (ev_all),
        .en_all  (en_all),
        .rd_grp  (rd_grp),
        .rd_kind (rd_kind),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/stat_tree_chk.sv
// Property checker for stat_tree, attached by bind. It keeps its own copy
// of the previous top-level external conditions to see rising edges.
module stat_tree_chk #(
    parameter int          GW        = 3,
    parameter logic [15:0] INST_MASK = 16'h007E
) (
    input logic        clk,
    input logic        rst_n,
    input logic        dev_rst,
    input logic        clr_stat,
    input logic [15:0] top_cond,
    input logic        rd_en,
    input logic [GW-1:0] rd_grp,
    input logic [1:0]  rd_kind,
    input logic [15:0] rd_data,
    input logic        summary_out,
    input logic [15:0] top_ev,
    input logic [15:0] top_en,
    input logic [15:0] inst_en
);
    logic [15:0] ext_prev;
    logic [15:0] ext_rise;
    logic        top_clr;

    // Previous masked external top conditions (bit 13 excluded).
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= '0;
        else        ext_prev <= top_cond & 16'h1838;
    end
    assign ext_rise = (top_cond & 16'h1838) & ~ext_prev;
    assign top_clr  = clr_stat || (rd_en && rd_kind == 2'd1 && rd_grp == GW'(0));

    AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rise != 0) |=> ((top_ev & $past(ext_rise)) == $past(ext_rise))); // R2
    AST_COND_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_kind == 2'd0 && !clr_stat) |=> (($past(top_ev) & ~top_ev) == 0)); // R1
    AST_EVENTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !top_clr |=> (($past(top_ev) & ~top_ev) == 0)); // R5
    AST_CLR_EMPTIES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |=> (top_en == 0 && inst_en == 0)); // R4
    AST_DEVRST_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> (top_en == 0 && inst_en == 0)); // R5
    AST_INST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grp == GW'(1)) |-> ((rd_data & ~INST_MASK) == 0)); // R7
    AST_SUMMARY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (top_en == 0) |-> !summary_out); // R6
endmodule

bind stat_tree stat_tree_chk #(.GW(GW), .INST_MASK(INST_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_rst    (dev_rst),
    .clr_stat   (clr_stat),
    .top_cond   (top_cond),
    .rd_en      (rd_en),
    .rd_grp     (rd_grp),
    .rd_kind    (rd_kind),
    .rd_data    (rd_data),
    .summary_out(summary_out),
    .top_ev     (top_ev_q),
    .top_en     (top_en_q),
    .inst_en    (inst_en_q)
);

// File: tb/stat_tree_test.sv
// Bench for stat_tree with six channels: per-bit sweeps and tree scenarios.
module stat_tree_test;
    localparam int NCH = 6;
    localparam int GW  = 3;
    localparam logic [15:0] CHM  = 16'd1 + 16'd2 + 16'd16 + 16'd256 + 16'd512 + 16'd1024;
    localparam logic [15:0] TOPX = 16'd8 + 16'd16 + 16'd32 + 16'd2048 + 16'd4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0, dev_rst = 1'b0, clr_stat = 1'b0;
    logic [15:0] top_cond = '0;
    logic [16*NCH-1:0] ch_cond = '0;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [GW-1:0] rd_grp = '0, wr_grp = '0;
    logic [1:0] rd_kind = '0;
    logic [15:0] wr_data = '0, rd_data;
    logic summary_out;
    int tests = 0, fails = 0;
    logic [15:0] v;

    always #2 clk = ~clk;

    stat_tree #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .clr_stat(clr_stat),
        .top_cond(top_cond), .ch_cond(ch_cond), .rd_en(rd_en), .rd_grp(rd_grp),
        .rd_kind(rd_kind), .rd_data(rd_data), .wr_en(wr_en), .wr_grp(wr_grp),
        .wr_data(wr_data), .summary_out(summary_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Advance past an edge and drop all strobes.
    task automatic step();
        @(posedge clk); #1;
        rd_en = 0; wr_en = 0; clr_stat = 0; dev_rst = 0;
    endtask

    // Start a read in the current cycle and sample the combinational data.
    task automatic peek(input int g, input int k, output logic [15:0] d);
        rd_en = 1; rd_grp = GW'(g); rd_kind = 2'(k);
        #1 d = rd_data;
    endtask

    task automatic wr(input int g, input logic [15:0] d);
        wr_en = 1; wr_grp = GW'(g); wr_data = d;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R9 reset state
        peek(0, 1, v); chk("R9 top event after reset", v, 16'h0);
        chk("R9 summary after reset", {15'b0, summary_out}, 16'h0);
        step();
        peek(0, 3, v); chk("R9 kind 3 reads zero", v, 16'h0);
        step();

        // Channel sweep: R1, R2, R3, R7 and R9 addressing
        for (int c = 0; c < NCH; c++) begin
            for (int b = 0; b < 16; b++) begin
                logic [15:0] e;
                e = CHM & (16'd1 << b);
                ch_cond = (96'(1) << (16*c + b));
                peek(2 + c, 0, v); chk("R1 channel cond view", v, e);
                step();
                ch_cond = '0;
                step();
                peek(2 + c, 1, v); chk("R2 channel sticky event", v, e);
                step();
                peek(2 + c, 1, v); chk("R3 channel cleared by read", v, 16'h0);
                step();
            end
        end

        // Top sweep: external bit 13 ignored (R7)
        for (int b = 0; b < 16; b++) begin
            logic [15:0] e;
            e = TOPX & (16'd1 << b);
            top_cond = 16'd1 << b;
            peek(0, 0, v); chk("R7 top cond view", v, e);
            step();
            top_cond = '0;
            step();
            peek(0, 1, v); chk("R2 top sticky event", v, e);
            step();
            peek(0, 1, v); chk("R3 top cleared by read", v, 16'h0);
            step();
        end

        // Enables and masks (R6, R7)
        wr(4, 16'hFFFF);
        peek(4, 2, v); chk("R6 channel enable masked", v, CHM); step();
        wr(1, 16'hFFFF);
        peek(1, 2, v); chk("R7 instrument enable bits 1..6", v, 16'h007E); step();
        wr(0, 16'h2000);

        // Cascade latency (R8): channel 2, bit 9
        ch_cond = 96'(1) << (16*2 + 9);
        step();  // E: channel event
        chk("R8 summary low after E", {15'b0, summary_out}, 16'h0);
        peek(1, 0, v); chk("R8 instrument cond bit 3", v, 16'h0008);
        step();  // E+1: instrument event
        chk("R8 summary low after E+1", {15'b0, summary_out}, 16'h0);
        peek(0, 0, v); chk("R8 top cond bit 13", v, 16'h2000);
        step();  // E+2: top event bit 13
        chk("R8 summary high after E+2", {15'b0, summary_out}, 16'h1);

        // Read-clear collides with a rise (R3)
        top_cond = 16'h0008;
        peek(0, 1, v); chk("R3 top event before collision", v, 16'h2000);
        step();
        peek(0, 1, v); chk("R3 rise kept on clearing edge", v, 16'h0008);
        top_cond = '0;
        step();
        chk("R3 summary low after clear", {15'b0, summary_out}, 16'h0);

        // Enable selection (R6)
        top_cond = 16'h0010;
        step();
        chk("R6 unselected event gives no summary", {15'b0, summary_out}, 16'h0);
        wr(0, 16'h0010);
        chk("R6 selected event gives summary", {15'b0, summary_out}, 16'h1);
        wr(0, 16'h0000);
        peek(0, 2, v); chk("R6 writing zero clears enable", v, 16'h0);
        chk("R6 summary low with zero enable", {15'b0, summary_out}, 16'h0);
        step();

        // Device reset (R5)
        wr(0, 16'h0010);
        dev_rst = 1;
        step();
        chk("R5 summary low after device reset", {15'b0, summary_out}, 16'h0);
        peek(4, 2, v); chk("R5 channel enable cleared", v, 16'h0); step();
        peek(0, 2, v); chk("R5 top enable cleared", v, 16'h0); step();
        peek(0, 1, v); chk("R5 top event kept", v, 16'h0010); step();

        // Clear status (R4)
        wr(4, 16'hFFFF);
        wr(1, 16'hFFFF);
        wr(0, 16'h2000);
        chk("R4 summary high before clear", {15'b0, summary_out}, 16'h1);
        clr_stat = 1;
        step();
        chk("R4 summary low after clear", {15'b0, summary_out}, 16'h0);
        peek(0, 2, v); chk("R4 top enable cleared", v, 16'h0); step();
        peek(1, 2, v); chk("R4 instrument enable cleared", v, 16'h0); step();
        peek(4, 2, v); chk("R4 channel enable cleared", v, 16'h0); step();
        peek(4, 1, v); chk("R4 channel event cleared", v, 16'h0); step();
        peek(1, 1, v); chk("R4 instrument event cleared", v, 16'h0); step();
        peek(0, 1, v); chk("R4 top event cleared", v, 16'h0); step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule